// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Buffer

This block is a direct-mapped data cache for a 32-bit little-endian processor. Each line holds one 32-bit word, and there are 256 lines, which gives 1 KB in total. Lines are found from the physical address. The block sits between the processor's load/store port and a slow main-memory port.

Every store is written through to memory. A store that hits also updates the bytes of the cached line that its byte enables select. A store that misses leaves the cache as it is. Each store enters a four-entry FIFO that keeps the address, byte enables and data. The processor continues while that FIFO drains to memory one handshake at a time.

Loads that hit return data in the cycle of the request. A load that misses fetches one word from memory and installs it in the line before it answers. If a queued store targets the same word, the FIFO drains first.

A single control machine sequences the block:

- **IDLE** serves hits and accepts stores.
- **IDLE → DRAIN** happens on a load miss whose word is still queued.
- **IDLE → FILL** happens on a load miss with no queued match.
- **DRAIN → FILL** happens once the FIFO is empty.
- **FILL → IDLE** happens on the memory acknowledge that returns the word.

Top module: `wt_dcache`

## Requirements
- R1: Reset clears every line's valid bit and discards all queued stores. After reset `mem_req` is low, a store queued before the reset never reaches memory, and the first load of any address misses.
- R2: Mapping is direct. The line index is address bits [9:2] and the tag is bits [31:10]. Two addresses with the same index and different tags evict each other.
- R3: A load that hits raises `cpu_ack` in the same cycle as `cpu_req`, returns the line's word, and starts no memory read.
- R4: A load that misses issues a memory read of the word-aligned address with `mem_we`=0 and `mem_be`=4'b1111. `cpu_ack` rises in the cycle of `mem_ack` with `mem_rdata`, and the line becomes valid, so a repeated load hits.
- R5: A store is acknowledged in its request cycle whenever fewer than 4 stores are queued.
- R6: While 4 stores are queued, a further store sees `cpu_ack` low until an entry retires.
- R7: A store hit replaces only the bytes whose enable is set. Enable bit i selects data bits [8i+7:8i], so byte 0 is bits [7:0]. A store miss allocates no line.
- R8: Queued stores retire in FIFO order, one per cycle with `mem_req` and `mem_ack` both high. Each retirement drives `mem_we`=1 with the stored address, enables and data.
- R9: A load miss whose word address matches a queued store issues no memory read until the FIFO is empty, so the fetched word already contains the store.
- R10: A load miss with no queued match takes the memory port ahead of pending stores. No store retires while the fill is outstanding.
- R11: Every accepted store appears on the memory port exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_be | input | 4 | Store byte enables, bit i = byte lane i |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write a queued store, 0 = line fill read |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, sampled with `mem_ack` |
| mem_ack | input | 1 | Transfer completes in this cycle |

## Verification
Load hits and accepted stores are due in the cycle of the request, with zero wait cycles. A fill answers in the cycle of `mem_ack`, which is one state cycle plus the memory latency after the request. A stalled store answers in the cycle after the first retirement.

The bench drives each request just after a falling edge and samples about 1 ns later, well away from the rising edge. It counts the falling edges until `cpu_ack` is seen and compares that count with the exact value the requirement predicts.

Memory-side order is checked against a log that the bench's memory model records at each handshake. Ordering claims are judged by comparing retirement counts at the moment the load answers.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FILL  = 2'd2
    } dc_state_e;
endpackage

// File: rtl/dc_lines.sv
`timescale 1ns/1ps
module dc_lines #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] lk_word,
    output logic                         lk_hit,
    output logic [DATA_W-1:0]            lk_data,
    input  logic                         fill_en,
    input  logic                         store_en,
    input  logic [DATA_W/8-1:0]          wr_be,
    input  logic [DATA_W-1:0]            wr_data
);
    localparam int BE_W  = DATA_W / 8;
    localparam int OFF_W = $clog2(BE_W);
    localparam int WRD_W = ADDR_W - OFF_W;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = WRD_W - IDX_W;

    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  valid_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] merged;

    assign idx     = lk_word[IDX_W-1:0];
    assign tag     = lk_word[WRD_W-1:IDX_W];
    assign lk_hit  = valid_q[idx] && (tag_q[idx] == tag);
    assign lk_data = data_q[idx];

    // little-endian lanes: enable bit b owns bits [8b+7:8b]
    always_comb begin
        for (int b = 0; b < BE_W; b++) begin
            merged[b*8 +: 8] = (fill_en || wr_be[b]) ? wr_data[b*8 +: 8]
                                                     : data_q[idx][b*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en || store_en) begin
            data_q[idx] <= merged;
        end
        if (fill_en) begin
            tag_q[idx] <= tag;
        end
    end

    // R7: byte updates only ever land on a line that hits
    a_r7_store_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> lk_hit);
    // R4: a fill is only issued for a line that missed
    a_r4_fill_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !lk_hit);
endmodule

// File: rtl/dc_wbuf.sv
`timescale 1ns/1ps
module dc_wbuf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [ADDR_W-1:0]            push_addr,
    input  logic [DATA_W/8-1:0]          push_be,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic                         full,
    output logic                         empty,
    output logic [ADDR_W-1:0]            head_addr,
    output logic [DATA_W/8-1:0]          head_be,
    output logic [DATA_W-1:0]            head_data,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] probe_word,
    output logic                         probe_hit
);
    localparam int BE_W  = DATA_W / 8;
    localparam int OFF_W = $clog2(BE_W);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [BE_W-1:0]   be_q   [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  match;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            vld_q  <= '0;
        end else begin
            if (push) begin
                vld_q[wr_ptr] <= 1'b1;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                vld_q[rd_ptr] <= 1'b0;
                rd_ptr        <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            be_q[wr_ptr]   <= push_be;
            data_q[wr_ptr] <= push_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_probe
        assign match[i] = vld_q[i] && (addr_q[i][ADDR_W-1:OFF_W] == probe_word);
    end

    assign probe_hit = |match;
    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = addr_q[rd_ptr];
    assign head_be   = be_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    // R6: the controller never pushes into a full buffer
    a_r6_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R8: a retirement always has an entry behind it
    a_r8_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R8: slot flags and occupancy counter stay consistent
    a_r8_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_q) == int'(count));
endmodule

// File: rtl/dc_ctrl.sv
`timescale 1ns/1ps
module dc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic lk_hit,
    input  logic wb_full,
    input  logic wb_empty,
    input  logic wb_probe_hit,
    input  logic mem_ack,
    output logic cpu_ack,
    output logic fill_own,
    output logic wb_push,
    output logic wb_pop,
    output logic store_en,
    output logic fill_en
);
    import dc_pkg::*;

    dc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && !cpu_we && !lk_hit) begin
                    state_d = wb_probe_hit ? ST_DRAIN : ST_FILL;
                end
            end
            ST_DRAIN: begin
                if (wb_empty) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ack  = 1'b0;
        fill_own = 1'b0;
        wb_push  = 1'b0;
        wb_pop   = 1'b0;
        store_en = 1'b0;
        fill_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wb_pop = mem_ack;
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (!wb_full) begin
                            cpu_ack  = 1'b1;
                            wb_push  = 1'b1;
                            store_en = lk_hit;
                        end
                    end else if (lk_hit) begin
                        cpu_ack = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                wb_pop = mem_ack;
            end
            ST_FILL: begin
                fill_own = 1'b1;
                if (mem_ack) begin
                    cpu_ack = 1'b1;
                    fill_en = 1'b1;
                end
            end
            default: begin
                cpu_ack = 1'b0;
            end
        endcase
    end

    // R9: no fill is outstanding while a matching store is still queued
    a_r9_fill_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !wb_probe_hit);
    // R9: draining only happens while stores are queued or just emptied
    a_r9_drain_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_DRAIN && state_q == ST_IDLE) |-> !wb_empty);
endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LINES    = 256,
    parameter int WB_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_ack,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ack
);
    localparam int BE_W  = DATA_W / 8;
    localparam int OFF_W = $clog2(BE_W);

    logic                    lk_hit;
    logic [DATA_W-1:0]       lk_data;
    logic                    fill_own, wb_push, wb_pop, store_en, fill_en;
    logic                    wb_full, wb_empty, wb_probe_hit;
    logic [ADDR_W-1:0]       head_addr;
    logic [BE_W-1:0]         head_be;
    logic [DATA_W-1:0]       head_data;
    logic [ADDR_W-OFF_W-1:0] cpu_word;

    assign cpu_word = cpu_addr[ADDR_W-1:OFF_W];

    dc_lines #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_word  (cpu_word),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .fill_en  (fill_en),
        .store_en (store_en),
        .wr_be    (cpu_be),
        .wr_data  (fill_en ? mem_rdata : cpu_wdata)
    );

    dc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wb_push),
        .push_addr  (cpu_addr),
        .push_be    (cpu_be),
        .push_data  (cpu_wdata),
        .pop        (wb_pop),
        .full       (wb_full),
        .empty      (wb_empty),
        .head_addr  (head_addr),
        .head_be    (head_be),
        .head_data  (head_data),
        .probe_word (cpu_word),
        .probe_hit  (wb_probe_hit)
    );

    dc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lk_hit       (lk_hit),
        .wb_full      (wb_full),
        .wb_empty     (wb_empty),
        .wb_probe_hit (wb_probe_hit),
        .mem_ack      (mem_ack),
        .cpu_ack      (cpu_ack),
        .fill_own     (fill_own),
        .wb_push      (wb_push),
        .wb_pop       (wb_pop),
        .store_en     (store_en),
        .fill_en      (fill_en)
    );

    // memory port: a fill owns it outright, otherwise the store FIFO head
    assign mem_req   = fill_own || !wb_empty;
    assign mem_we    = !fill_own;
    assign mem_addr  = fill_own ? {cpu_word, {OFF_W{1'b0}}} : head_addr;
    assign mem_be    = fill_own ? {BE_W{1'b1}} : head_be;
    assign mem_wdata = head_data;
    assign cpu_rdata = fill_own ? mem_rdata : lk_data;

    // R6: a store is held off while the FIFO is full
    a_r6_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && wb_full) |-> !cpu_ack);
    // R4: fills are whole aligned words
    a_r4_fill_word_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == {BE_W{1'b1}} && mem_addr[OFF_W-1:0] == '0));
    // R11: an accepted store is on the memory port in the next cycle
    a_r11_store_posted: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ack) |=> (mem_req && mem_we));
    // R8: a pending memory request is not withdrawn before it completes
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);
endmodule

// File: tb/sim_wt_dcache.sv
`timescale 1ns/1ps
module sim_wt_dcache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;

    always #5 clk = ~clk;

    wt_dcache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_checks = 0, n_fail = 0;
    int lat = 2, wcnt = 0;
    int n_wr = 0, n_rd = 0, n_st = 0;
    logic [31:0] mem_words [logic [29:0]];
    logic [67:0] wlog [$];

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return {a[17:2], ~a[17:2]};
    endfunction

    function logic [31:0] mem_read(input logic [31:0] a);
        if (mem_words.exists(a[31:2])) return mem_words[a[31:2]];
        return init_word(a);
    endfunction

    // slow memory: acknowledges after lat consecutive request cycles
    assign mem_ack = mem_req && (wcnt >= lat);

    always @(negedge clk) mem_rdata <= mem_read(mem_addr);

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            wcnt <= 0;
            if (mem_we) begin
                logic [31:0] w;
                w = mem_read(mem_addr);
                for (int b = 0; b < 4; b++) if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
                mem_words[mem_addr[31:2]] = w;
                wlog.push_back({mem_addr, mem_be, mem_wdata});
                n_wr++;
            end else begin
                n_rd++;
            end
        end else if (mem_req) begin
            wcnt <= wcnt + 1;
        end else begin
            wcnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        waits = 0;
        #1;
        while (!cpu_ack && waits < 2000) begin
            @(negedge clk); #1; waits++;
        end
        rd = cpu_rdata;
        if (we && cpu_ack) n_st++;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_drain();
        for (int t = 0; t < 1000 && n_wr != n_st; t++) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1;
        check(mem_req == 1'b0, "R1 mem_req after reset", 68'(mem_req), 68'(0));
        check(cpu_ack == 1'b0, "R1 cpu_ack after reset", 68'(cpu_ack), 68'(0));
    endtask

    task automatic t_read_miss_hit();
        logic [31:0] d; int w; int rd0;
        rd0 = n_rd;
        cpu_op(1'b0, 32'h0000_0140, 4'h0, '0, d, w);
        check(w == lat + 1, "R1 R4 first load misses, wait cycles", 68'(w), 68'(lat + 1));
        check(d == init_word(32'h140), "R4 fill data", 68'(d), 68'(init_word(32'h140)));
        check(n_rd == rd0 + 1, "R4 one memory read", 68'(n_rd), 68'(rd0 + 1));
        cpu_op(1'b0, 32'h0000_0140, 4'h0, '0, d, w);
        check(w == 0, "R3 hit answers in request cycle", 68'(w), 68'(0));
        check(d == init_word(32'h140), "R3 hit data", 68'(d), 68'(init_word(32'h140)));
        check(n_rd == rd0 + 1, "R3 hit makes no memory read", 68'(n_rd), 68'(rd0 + 1));
    endtask

    task automatic t_store_hit_bytes();
        logic [31:0] d, exp; int w;
        cpu_op(1'b0, 32'h0000_0180, 4'h0, '0, d, w);
        cpu_op(1'b1, 32'h0000_0180, 4'b0101, 32'hAABB_CCDD, d, w);
        check(w == 0, "R5 store accepted at once", 68'(w), 68'(0));
        exp = (init_word(32'h180) & 32'hFF00_FF00) | (32'hAABB_CCDD & 32'h00FF_00FF);
        cpu_op(1'b0, 32'h0000_0180, 4'h0, '0, d, w);
        check(w == 0, "R7 line still hits after store", 68'(w), 68'(0));
        check(d == exp, "R7 only enabled lanes changed", 68'(d), 68'(exp));
        wait_drain();
        check(wlog[wlog.size()-1] == {32'h0000_0180, 4'b0101, 32'hAABB_CCDD},
              "R11 store written through", wlog[wlog.size()-1], {32'h0000_0180, 4'b0101, 32'hAABB_CCDD});
    endtask

    task automatic t_store_miss_then_load();
        logic [31:0] d; int w; int wr0;
        wait_drain();
        wr0 = n_wr;
        cpu_op(1'b1, 32'h0000_2040, 4'hF, 32'hDEAD_BEEF, d, w);
        cpu_op(1'b0, 32'h0000_2040, 4'h0, '0, d, w);
        check(w != 0, "R7 store miss did not allocate", 68'(w), 68'(1));
        check(d == 32'hDEAD_BEEF, "R9 fetched word includes queued store", 68'(d), 68'(32'hDEAD_BEEF));
        check(n_wr == wr0 + 1, "R9 store retired before fill", 68'(n_wr), 68'(wr0 + 1));
    endtask

    task automatic t_conflict();
        logic [31:0] d; int w;
        cpu_op(1'b0, 32'h0000_0104, 4'h0, '0, d, w);
        cpu_op(1'b0, 32'h0000_0504, 4'h0, '0, d, w);
        check(w != 0, "R2 same index other tag misses", 68'(w), 68'(1));
        check(d == init_word(32'h504), "R2 conflicting line data", 68'(d), 68'(init_word(32'h504)));
        cpu_op(1'b0, 32'h0000_0104, 4'h0, '0, d, w);
        check(w != 0, "R2 first line was evicted", 68'(w), 68'(1));
        check(d == init_word(32'h104), "R2 refetched data", 68'(d), 68'(init_word(32'h104)));
    endtask

    task automatic t_buffer_full();
        logic [31:0] d; int w; int wr0; int base;
        wait_drain();
        lat = 8;
        wr0 = n_wr;
        base = wlog.size();
        for (int i = 0; i < 5; i++) begin
            cpu_op(1'b1, 32'h0000_3000 + 32'(i * 4), 4'hF, 32'hC0DE_0000 + 32'(i), d, w);
            if (i < 4) check(w == 0, "R5 store accepted with free slot", 68'(w), 68'(0));
            else check(w > 0, "R6 fifth store stalls while full", 68'(w), 68'(1));
        end
        wait_drain();
        check(n_wr == wr0 + 5, "R11 each store written once", 68'(n_wr), 68'(wr0 + 5));
        for (int i = 0; i < 5; i++) begin
            logic [67:0] e;
            e = {32'h0000_3000 + 32'(i * 4), 4'hF, 32'hC0DE_0000 + 32'(i)};
            check(wlog[base + i] == e, "R8 retire order", wlog[base + i], e);
        end
        lat = 2;
    endtask

    task automatic t_fill_preempt();
        logic [31:0] d; int w; int wr0;
        wait_drain();
        lat = 4;
        wr0 = n_wr;
        cpu_op(1'b1, 32'h0000_3100, 4'hF, 32'h1122_3344, d, w);
        cpu_op(1'b0, 32'h0000_3200, 4'h0, '0, d, w);
        check(n_wr == wr0, "R10 fill served before pending store", 68'(n_wr), 68'(wr0));
        check(d == init_word(32'h3200), "R10 fill data", 68'(d), 68'(init_word(32'h3200)));
        wait_drain();
        check(n_wr == wr0 + 1, "R10 store retires after fill", 68'(n_wr), 68'(wr0 + 1));
        lat = 2;
    endtask

    task automatic t_reset_midflight();
        logic [31:0] d; int w; int wr0;
        wait_drain();
        lat = 8;
        wr0 = n_wr;
        cpu_op(1'b1, 32'h0000_3300, 4'hF, 32'h5555_AAAA, d, w);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_st = n_wr;
        #1;
        check(mem_req == 1'b0, "R1 reset empties store FIFO", 68'(mem_req), 68'(0));
        repeat (12) @(negedge clk);
        check(n_wr == wr0, "R1 discarded store never written", 68'(n_wr), 68'(wr0));
        lat = 2;
        cpu_op(1'b0, 32'h0000_0140, 4'h0, '0, d, w);
        check(w == lat + 1, "R1 reset invalidated cached line", 68'(w), 68'(lat + 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_read_miss_hit();
        t_store_hit_bytes();
        t_store_miss_then_load();
        t_conflict();
        t_buffer_full();
        t_fill_preempt();
        t_reset_midflight();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1-R11 act=timeout exp=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule